// File: doc/BRIEF.md
# Palette DAC Input Source Selector

This block sits in front of a palette DAC and decides, per signal group, whether the native display controller or an add-in adapter drives the DAC's inputs. Three active-low ownership inputs steer the block. A high level means the native controller owns the group and a low level means the adapter owns it. The three groups are the blank/horizontal-sync/vertical-sync group, the 8-bit pixel address bus and the dot-clock source. The ownership inputs and a 3-bit clock-select value are registered once. After reset they come up as native ownership, which stands in for the board pull-ups.

The whole design runs on one fast system clock. Each source marks its rising dot-clock edge with a one-cycle capture strobe. The strobe that counts is chosen by the clock-ownership bit. On a selected strobe the chosen pixel address and the chosen sync group are latched together into the DAC-side register. The latched pixel is forced to zero while the latched blank is active.

Two sticky flags report bad configurations. The first is an ownership conflict: the adapter clocks the DAC but the native controller still supplies the pixels. The second is a clock-select value that does not fit the clock owner. Each flag stays set until a write-one-to-clear pulse removes it.

Top module: `vdac_input_sel`

## Requirements
- R1: Synchronous active-high reset. It sets the ownership register to all-native (all three bits 1) and the clock-select register to 3'b000. It clears both error flags. It sets dac_pix to 0, dac_blank_n to 0, dac_hs to 0, dac_vs to 0 and dac_stb to 0.
- R2: The ownership inputs and clk_sel are sampled on every clock and take effect on the clock after they are sampled. With the registered own_sync_n at 1, the native blank_n, hs and vs are latched. With it at 0, the adapter's are latched.
- R3: With the registered own_pix_n at 1, the native 8-bit pixel address is latched. With it at 0, the adapter's pixel address is latched.
- R4: With the registered own_clk_n at 1, only nat_stb causes a capture. With it at 0, only adp_stb causes a capture. In a cycle with no selected strobe, dac_pix, dac_blank_n, dac_hs and dac_vs hold their values.
- R5: The pixel and the sync group are captured on the same selected strobe. Outputs change one clock after the strobe cycle, so all four outputs stay aligned.
- R6: When the captured blank_n is 0 (blank active), dac_pix is 0 whatever pixel value was selected.
- R7: err_own sets one clock after the registered ownership shows own_clk_n = 0 together with own_pix_n = 1.
- R8: err_cfg sets one clock after the registered state shows a clock-select mismatch. The adapter owns the clock (own_clk_n = 0) and clk_sel differs from 3'b010, or the native controller owns the clock (own_clk_n = 1) and clk_sel equals 3'b010.
- R9: Error flags are sticky. err_clr[0] clears err_own and err_clr[1] clears err_cfg. A clear takes effect on the next clock. If the error condition is still present in that cycle, the flag stays set.
- R10: dac_stb is high for exactly the cycles that follow a cycle in which the selected strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_sync_n | input | 1 | Sync/blank group owner (1 native, 0 adapter) |
| own_pix_n | input | 1 | Pixel address owner (1 native, 0 adapter) |
| own_clk_n | input | 1 | Dot-clock owner (1 native, 0 adapter) |
| clk_sel | input | 3 | Clock-select register value |
| nat_stb | input | 1 | Native dot-clock rising-edge strobe |
| nat_pix | input | 8 | Native pixel address |
| nat_blank_n | input | 1 | Native blank, active low |
| nat_hs | input | 1 | Native horizontal sync |
| nat_vs | input | 1 | Native vertical sync |
| adp_stb | input | 1 | Adapter dot-clock rising-edge strobe |
| adp_pix | input | 8 | Adapter pixel address |
| adp_blank_n | input | 1 | Adapter blank, active low |
| adp_hs | input | 1 | Adapter horizontal sync |
| adp_vs | input | 1 | Adapter vertical sync |
| err_clr | input | 2 | Write-one-to-clear: bit 0 err_own, bit 1 err_cfg |
| dac_pix | output | 8 | Latched pixel address to the DAC |
| dac_blank_n | output | 1 | Latched blank, active low |
| dac_hs | output | 1 | Latched horizontal sync |
| dac_vs | output | 1 | Latched vertical sync |
| dac_stb | output | 1 | Capture happened on the previous clock |
| err_own | output | 1 | Sticky ownership-conflict flag |
| err_cfg | output | 1 | Sticky clock-select mismatch flag |

## Verification
The hardest cases to reach are the ones where ownership changes next to a strobe. The block still acts on the old owner for one clock, so a strobe from the previous clock owner in that cycle must still be captured. A strobe from the new owner arriving too early must be ignored. The stimulus reaches this in two ways. Directed steps switch ownership and place strobes from both sources at the switch point. A long random phase toggles the ownership bits, the clock-select value, both strobes and the clear pulses on independent probabilities. A behavioural reference model is compared with the outputs on every clock.

// File: rtl/vdac_sel_pkg.sv
package vdac_sel_pkg;

    localparam int PIX_W_DEF   = 8;
    localparam int SEL_W_DEF   = 3;
    localparam int EXT_SEL_DEF = 2;   // clock-select code required when the adapter clocks

    localparam int ERR_OWN_BIT = 0;
    localparam int ERR_CFG_BIT = 1;
    localparam int NUM_ERR     = 2;

    // ownership of each group: 1 = native controller, 0 = adapter
    typedef struct packed {
        logic sync_n;
        logic pix_n;
        logic clk_n;
    } own_t;

    localparam own_t OWN_NATIVE = '{sync_n: 1'b1, pix_n: 1'b1, clk_n: 1'b1};

    typedef struct packed {
        logic blank_n;
        logic hs;
        logic vs;
    } sync_grp_t;

    localparam sync_grp_t SYNC_RST = '{blank_n: 1'b0, hs: 1'b0, vs: 1'b0};

    function automatic logic own_conflict(own_t o);
        return (o.clk_n == 1'b0) && (o.pix_n == 1'b1);
    endfunction

    function automatic logic sel_mismatch(own_t o, logic sel_is_ext);
        return o.clk_n ? sel_is_ext : !sel_is_ext;
    endfunction

endpackage

// File: rtl/vdac_ctrl_reg.sv
module vdac_ctrl_reg
    import vdac_sel_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  own_t             own_in,
    input  logic [SEL_W-1:0] sel_in,
    output own_t             own_q,
    output logic [SEL_W-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= OWN_NATIVE;
            sel_q <= '0;
        end else begin
            own_q <= own_in;
            sel_q <= sel_in;
        end
    end

    // R1
    reset_native_chk: assert property (@(posedge clk)
        rst |=> (own_q == OWN_NATIVE) && (sel_q == '0));

    // R2
    own_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (own_q == $past(own_in)));

endmodule

// File: rtl/vdac_src_mux.sv
module vdac_src_mux
    import vdac_sel_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  own_t             own_q,
    input  logic             nat_stb,
    input  logic [PIX_W-1:0] nat_pix,
    input  sync_grp_t        nat_sync,
    input  logic             adp_stb,
    input  logic [PIX_W-1:0] adp_pix,
    input  sync_grp_t        adp_sync,
    output logic             sel_stb,
    output logic [PIX_W-1:0] sel_pix,
    output sync_grp_t        sel_sync
);

    // one select bit per group: index 0 clock, 1 pixel, 2 sync
    localparam int NGRP = 3;
    logic [NGRP-1:0] use_nat;

    assign use_nat = {own_q.sync_n, own_q.pix_n, own_q.clk_n};

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            if (g == 0) begin : g_clk
                assign sel_stb = use_nat[g] ? nat_stb : adp_stb;
            end else if (g == 1) begin : g_pix
                assign sel_pix = use_nat[g] ? nat_pix : adp_pix;
            end else begin : g_sync
                assign sel_sync = use_nat[g] ? nat_sync : adp_sync;
            end
        end
    endgenerate

endmodule

// File: rtl/vdac_out_reg.sv
module vdac_out_reg
    import vdac_sel_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [PIX_W-1:0] pix_in,
    input  sync_grp_t        sync_in,
    output logic [PIX_W-1:0] pix_q,
    output sync_grp_t        sync_q,
    output logic             cap_q
);

    logic [PIX_W-1:0] pix_gated;

    always_comb begin
        pix_gated = sync_in.blank_n ? pix_in : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            sync_q <= SYNC_RST;
            cap_q  <= 1'b0;
        end else begin
            cap_q <= cap;
            if (cap) begin
                pix_q  <= pix_gated;
                sync_q <= sync_in;
            end
        end
    end

    // R4
    hold_no_cap_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(pix_q) && $stable(sync_q));

    // R6
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && !sync_in.blank_n) |=> (pix_q == '0));

    // R10
    cap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> cap_q);

endmodule

// File: rtl/vdac_err_flags.sv
module vdac_err_flags #(
    parameter int NERR = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NERR-1:0] set_in,
    input  logic [NERR-1:0] clr_in,
    output logic [NERR-1:0] flag_q
);

    genvar i;
    generate
        for (i = 0; i < NERR; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q[i] <= 1'b0;
                end else if (set_in[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (clr_in[i]) begin
                    flag_q[i] <= 1'b0;
                end
            end

            // R9
            sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && !clr_in[i]) |=> flag_q[i]);

            // R9
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                set_in[i] |=> flag_q[i]);
        end
    endgenerate

endmodule

// File: rtl/vdac_input_sel.sv
module vdac_input_sel
    import vdac_sel_pkg::*;
#(
    parameter int                 PIX_W   = PIX_W_DEF,
    parameter int                 SEL_W   = SEL_W_DEF,
    parameter logic [SEL_W-1:0]   EXT_SEL = SEL_W'(EXT_SEL_DEF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             own_sync_n,
    input  logic             own_pix_n,
    input  logic             own_clk_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             nat_stb,
    input  logic [PIX_W-1:0] nat_pix,
    input  logic             nat_blank_n,
    input  logic             nat_hs,
    input  logic             nat_vs,
    input  logic             adp_stb,
    input  logic [PIX_W-1:0] adp_pix,
    input  logic             adp_blank_n,
    input  logic             adp_hs,
    input  logic             adp_vs,
    input  logic [1:0]       err_clr,
    output logic [PIX_W-1:0] dac_pix,
    output logic             dac_blank_n,
    output logic             dac_hs,
    output logic             dac_vs,
    output logic             dac_stb,
    output logic             err_own,
    output logic             err_cfg
);

    own_t             own_in, own_q;
    logic [SEL_W-1:0] sel_q;
    sync_grp_t        nat_sync, adp_sync, sel_sync, dac_sync;
    logic             sel_stb;
    logic [PIX_W-1:0] sel_pix;
    logic [NUM_ERR-1:0] err_set, err_q;

    assign own_in   = '{sync_n: own_sync_n, pix_n: own_pix_n, clk_n: own_clk_n};
    assign nat_sync = '{blank_n: nat_blank_n, hs: nat_hs, vs: nat_vs};
    assign adp_sync = '{blank_n: adp_blank_n, hs: adp_hs, vs: adp_vs};

    vdac_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .own_in (own_in),
        .sel_in (clk_sel),
        .own_q  (own_q),
        .sel_q  (sel_q)
    );

    vdac_src_mux #(.PIX_W(PIX_W)) u_mux (
        .own_q    (own_q),
        .nat_stb  (nat_stb),
        .nat_pix  (nat_pix),
        .nat_sync (nat_sync),
        .adp_stb  (adp_stb),
        .adp_pix  (adp_pix),
        .adp_sync (adp_sync),
        .sel_stb  (sel_stb),
        .sel_pix  (sel_pix),
        .sel_sync (sel_sync)
    );

    vdac_out_reg #(.PIX_W(PIX_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .cap     (sel_stb),
        .pix_in  (sel_pix),
        .sync_in (sel_sync),
        .pix_q   (dac_pix),
        .sync_q  (dac_sync),
        .cap_q   (dac_stb)
    );

    always_comb begin
        err_set              = '0;
        err_set[ERR_OWN_BIT] = own_conflict(own_q);
        err_set[ERR_CFG_BIT] = sel_mismatch(own_q, sel_q == EXT_SEL);
    end

    vdac_err_flags #(.NERR(NUM_ERR)) u_err (
        .clk    (clk),
        .rst    (rst),
        .set_in (err_set),
        .clr_in (err_clr),
        .flag_q (err_q)
    );

    assign dac_blank_n = dac_sync.blank_n;
    assign dac_hs      = dac_sync.hs;
    assign dac_vs      = dac_sync.vs;
    assign err_own     = err_q[ERR_OWN_BIT];
    assign err_cfg     = err_q[ERR_CFG_BIT];

    // R7
    own_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (!own_q.clk_n && own_q.pix_n) |=> err_own);

    // R8
    adp_sel_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (!own_q.clk_n && sel_q != EXT_SEL) |=> err_cfg);

    // R8
    nat_sel_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (own_q.clk_n && sel_q == EXT_SEL) |=> err_cfg);

    // R2
    sync_native_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_stb && own_q.sync_n) |=> (dac_hs == $past(nat_hs)) && (dac_vs == $past(nat_vs)));

    // R5
    adp_pix_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_stb && !own_q.pix_n && adp_blank_n && !own_q.sync_n)
            |=> (dac_pix == $past(adp_pix)) && dac_blank_n);

endmodule

// File: tb/vdac_input_sel_tb.sv
module vdac_input_sel_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic own_sync_n = 1'b1, own_pix_n = 1'b1, own_clk_n = 1'b1;
    logic [2:0] clk_sel = 3'b000;
    logic nat_stb = 1'b0, adp_stb = 1'b0;
    logic [7:0] nat_pix = 8'h00, adp_pix = 8'h00;
    logic nat_blank_n = 1'b1, nat_hs = 1'b0, nat_vs = 1'b0;
    logic adp_blank_n = 1'b1, adp_hs = 1'b0, adp_vs = 1'b0;
    logic [1:0] err_clr = 2'b00;
    logic [7:0] dac_pix;
    logic dac_blank_n, dac_hs, dac_vs, dac_stb, err_own, err_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    vdac_input_sel u_dut (
        .clk(clk), .rst(rst),
        .own_sync_n(own_sync_n), .own_pix_n(own_pix_n), .own_clk_n(own_clk_n),
        .clk_sel(clk_sel),
        .nat_stb(nat_stb), .nat_pix(nat_pix), .nat_blank_n(nat_blank_n),
        .nat_hs(nat_hs), .nat_vs(nat_vs),
        .adp_stb(adp_stb), .adp_pix(adp_pix), .adp_blank_n(adp_blank_n),
        .adp_hs(adp_hs), .adp_vs(adp_vs),
        .err_clr(err_clr),
        .dac_pix(dac_pix), .dac_blank_n(dac_blank_n), .dac_hs(dac_hs),
        .dac_vs(dac_vs), .dac_stb(dac_stb), .err_own(err_own), .err_cfg(err_cfg)
    );

    // behavioural reference state
    bit        m_os, m_op, m_oc;
    bit [2:0]  m_sel;
    bit [7:0]  m_pix;
    bit        m_bn, m_hs, m_vs, m_stb, m_eo, m_ec;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        started = 1'b1;
        if (rst) begin
            m_os = 1; m_op = 1; m_oc = 1; m_sel = 0;
            m_pix = 0; m_bn = 0; m_hs = 0; m_vs = 0; m_stb = 0; m_eo = 0; m_ec = 0;
        end else begin
            bit s;
            bit bad_own, bad_cfg;
            s = m_oc ? nat_stb : adp_stb;
            bad_own = !m_oc && m_op;
            bad_cfg = m_oc ? (m_sel == 3'b010) : (m_sel != 3'b010);
            m_eo = bad_own ? 1'b1 : (err_clr[0] ? 1'b0 : m_eo);
            m_ec = bad_cfg ? 1'b1 : (err_clr[1] ? 1'b0 : m_ec);
            if (s) begin
                m_bn  = m_os ? nat_blank_n : adp_blank_n;
                m_hs  = m_os ? nat_hs : adp_hs;
                m_vs  = m_os ? nat_vs : adp_vs;
                m_pix = !m_bn ? 8'h00 : (m_op ? nat_pix : adp_pix);
            end
            m_stb = s;
            m_os = own_sync_n; m_op = own_pix_n; m_oc = own_clk_n; m_sel = clk_sel;
        end
    end

    // per-clock comparison, one time unit after the edge
    always @(posedge clk) begin
        #1;
        if (started) begin
            check("R3/R6 dac_pix", dac_pix, m_pix);
            check("R2 dac_blank_n", dac_blank_n, m_bn);
            check("R2/R5 dac_hs", dac_hs, m_hs);
            check("R2/R5 dac_vs", dac_vs, m_vs);
            check("R10 dac_stb", dac_stb, m_stb);
            check("R7 err_own", err_own, m_eo);
            check("R8 err_cfg", err_cfg, m_ec);
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic idle_strobes();
        nat_stb = 0; adp_stb = 0; err_clr = 2'b00;
    endtask

    initial begin
        tick(3);
        // R1 reset state
        check("R1 dac_pix", dac_pix, 8'h00);
        check("R1 dac_blank_n", dac_blank_n, 1'b0);
        check("R1 err_own", err_own, 1'b0);
        check("R1 err_cfg", err_cfg, 1'b0);
        rst = 0;
        tick(2);

        // R3 native pixel and R2 native sync on a native strobe
        nat_stb = 1; nat_pix = 8'hA5; nat_blank_n = 1; nat_hs = 1; nat_vs = 0;
        adp_stb = 1; adp_pix = 8'h3C; adp_hs = 0; adp_vs = 1;
        tick(1);
        idle_strobes();
        check("R3 native pixel", dac_pix, 8'hA5);
        check("R2 native hs", dac_hs, 1'b1);
        check("R10 strobe pulse", dac_stb, 1'b1);
        tick(1);
        check("R10 strobe one cycle", dac_stb, 1'b0);

        // R6 blank forces zero
        nat_stb = 1; nat_pix = 8'hFF; nat_blank_n = 0;
        tick(1);
        idle_strobes();
        check("R6 blanked pixel", dac_pix, 8'h00);
        check("R6 blank latched", dac_blank_n, 1'b0);

        // R4 hold without a selected strobe: adapter strobe ignored while native clocks
        nat_blank_n = 1; nat_pix = 8'h11; adp_stb = 1; adp_pix = 8'h77;
        tick(3);
        idle_strobes();
        check("R4 hold on foreign strobe", dac_pix, 8'h00);

        // hand everything to the adapter with a matching clock select
        own_sync_n = 0; own_pix_n = 0; own_clk_n = 0; clk_sel = 3'b010;
        // R2 one-cycle lag: native strobe in the switch cycle still captures
        nat_stb = 1; nat_pix = 8'h42; nat_hs = 0; nat_vs = 1;
        tick(1);
        idle_strobes();
        check("R2 old owner still active", dac_pix, 8'h42);
        nat_stb = 1; nat_pix = 8'h99;
        tick(1);
        idle_strobes();
        check("R4 native strobe ignored", dac_pix, 8'h42);

        // R5 aligned adapter capture
        adp_stb = 1; adp_pix = 8'h5A; adp_blank_n = 1; adp_hs = 1; adp_vs = 0;
        tick(1);
        idle_strobes();
        check("R5 adapter pixel", dac_pix, 8'h5A);
        check("R5 adapter hs", dac_hs, 1'b1);
        check("R5 adapter vs", dac_vs, 1'b0);
        check("R8 legal select", err_cfg, 1'b0);

        // R7 adapter clocks, native pixels
        own_pix_n = 1;
        tick(2);
        check("R7 conflict flagged", err_own, 1'b1);
        own_pix_n = 0;
        tick(3);
        check("R9 sticky", err_own, 1'b1);
        err_clr = 2'b01;
        tick(1);
        err_clr = 2'b00;
        check("R9 cleared", err_own, 1'b0);

        // R8 native clock with the adapter select code
        own_clk_n = 1;
        tick(3);
        check("R8 native with 010", err_cfg, 1'b1);
        // R9 clear while condition persists keeps the flag
        err_clr = 2'b10;
        tick(1);
        err_clr = 2'b00;
        check("R9 set beats clear", err_cfg, 1'b1);
        clk_sel = 3'b001;
        tick(2);
        err_clr = 2'b10;
        tick(1);
        err_clr = 2'b00;
        check("R9 clear after fix", err_cfg, 1'b0);
        // R8 adapter clock with a wrong select code
        own_clk_n = 0;
        tick(3);
        check("R8 adapter with 001", err_cfg, 1'b1);

        // random phase against the reference model
        for (int i = 0; i < 3000; i++) begin
            own_sync_n  = ($urandom_range(0, 7) != 0) ? own_sync_n : ~own_sync_n;
            own_pix_n   = ($urandom_range(0, 7) != 0) ? own_pix_n : ~own_pix_n;
            own_clk_n   = ($urandom_range(0, 7) != 0) ? own_clk_n : ~own_clk_n;
            clk_sel     = ($urandom_range(0, 3) == 0) ? 3'($urandom) :
                          (own_clk_n ? 3'b000 : 3'b010);
            nat_stb     = 1'($urandom);
            adp_stb     = 1'($urandom);
            nat_pix     = 8'($urandom);
            adp_pix     = 8'($urandom);
            nat_blank_n = ($urandom_range(0, 4) != 0);
            adp_blank_n = ($urandom_range(0, 4) != 0);
            nat_hs = 1'($urandom); nat_vs = 1'($urandom);
            adp_hs = 1'($urandom); adp_vs = 1'($urandom);
            err_clr     = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
            if (i == 1500) rst = 1;
            if (i == 1503) rst = 0;
            tick(1);
        end

        idle_strobes();
        tick(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule